// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block connects an internal synchronous request port to an external asynchronous static RAM. The default memory is 32K words of 8 bits. The controller accepts one request at a time through a valid/ready handshake. It then drives the memory's address, its three active-low strobes (chip select, output enable and write enable) and a shared tri-state data bus. Each access is ordered so that the memory's timing rules are met: address and data are settled before the strobe opens, the strobe is held long enough, and everything is kept stable until after the strobe has closed.

Every access runs through the same fixed sequence: a setup phase, a strobe phase, a hold phase and a bus turnaround phase. Each phase lasts a whole number of system clock cycles, and each count is a parameter that is raised to at least one cycle. A write is the window in which chip select and write enable are both low. The write data is driven from the first setup cycle to the last hold cycle, so it is stable well before the edge that closes the write. Read data is captured at the end of the strobe phase. The turnaround phase gives the memory time to float its outputs before the controller may drive the bus again.

Back-pressure rules: `req_ready` is high only while the controller is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high, and its fields are copied at that edge. The controller ignores the request fields while it is busy. A requester may keep `req_valid` high while it waits. The response is a single-cycle pulse on `rsp_valid` with no back-pressure, so the requester must accept it in that cycle.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted, all three memory strobes are high and `rsp_valid` is low. After reset is released, `req_ready` is high.
- R2: `req_ready` is high only while idle. A request is taken only on an edge with `req_valid` and `req_ready` both high. Request fields that change after acceptance have no effect on the access in progress. A request held valid during a busy access is taken as soon as `req_ready` returns.
- R3: Counting the cycle after the accepting edge as cycle 1, chip select is low for cycles 1 to S+T+H and high afterwards. While chip select is low, the memory address equals the accepted address. S, T and H are the setup, strobe and hold counts.
- R4: In a write (`req_we`=1), write enable is low for exactly cycles S+1 to S+T and output enable stays high for the whole access.
- R5: In a write, the controller drives the accepted data on the bus in cycles 1 to S+H+T, so the data is stable for S cycles before write enable falls and until write enable has risen. That data ends up stored in the addressed memory word.
- R6: In a read (`req_we`=0), output enable is low for exactly cycles S+1 to S+T, write enable stays high, and the controller does not drive the bus.
- R7: The read data is captured from the bus in the last strobe cycle. It is presented on `rsp_rdata` together with `rsp_valid`.
- R8: `rsp_valid` is high for exactly one cycle per access, in cycle S+T+H, for both reads and writes.
- R9: After chip select rises, `req_ready` stays low for the R turnaround cycles and is high again in cycle S+T+H+R+1. The controller never drives the bus while the memory may still be driving it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (15) | Word address |
| req_wdata | input | DW (8) | Write data |
| rsp_valid | output | 1 | Access finished (one-cycle pulse) |
| rsp_rdata | output | DW (8) | Read data, valid with `rsp_valid` after a read |
| mem_addr | output | AW (15) | Memory address lines |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq | inout | DW (8) | Shared memory data bus |

## Verification
The assertions assume three things about the environment. The phase counts are long enough, in clock cycles, for the memory's nanosecond limits. The memory releases its outputs within one turnaround phase after output enable rises. The requester takes every `rsp_valid` pulse in the cycle it appears. The stimulus respects these assumptions. The bench builds a narrow 8-bit-address copy of the controller, whose stored word count fits a bench memory model. That model floats its outputs 6 ns after release, which is shorter than one 8 ns cycle. It also checks the write-pulse width and the data setup time against its own nanosecond limits. The bench samples every response on the cycle it is pulsed.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_TURN
  } phase_e;

  function automatic int at_least_one(input int n);
    return (n < 1) ? 1 : n;
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/asram_phase_timer.sv
`timescale 1ns/1ps
module asram_phase_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - CW'(1);
    end
  end

  assign last = (cnt == '0);

endmodule

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
module asram_seq #(
  parameter int T_SETUP  = 1,
  parameter int T_STROBE = 2,
  parameter int T_HOLD   = 1,
  parameter int T_TURN   = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_we,
  output logic req_ready,
  output logic accept,
  output logic cap_rd,
  output logic rsp_valid,
  output logic mem_ce_n,
  output logic mem_oe_n,
  output logic mem_we_n,
  output logic drive_en
);
  import asram_pkg::*;

  localparam int SC   = at_least_one(T_SETUP);
  localparam int TC   = at_least_one(T_STROBE);
  localparam int HC   = at_least_one(T_HOLD);
  localparam int RC   = at_least_one(T_TURN);
  localparam int TMAX = max4(SC, TC, HC, RC);
  localparam int CW   = (TMAX < 2) ? 1 : $clog2(TMAX);
  localparam int RW   = $clog2(TC + 2);

  phase_e        ph, ph_nxt;
  logic          op_we, nxt_we;
  logic          t_load, t_last;
  logic [CW-1:0] t_val;
  logic          nxt_busy;

  asram_phase_timer #(.CW(CW)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .last     (t_last)
  );

  always_comb begin
    ph_nxt = ph;
    t_load = 1'b0;
    t_val  = '0;
    unique case (ph)
      PH_IDLE: if (req_valid) begin
        ph_nxt = PH_SETUP;  t_load = 1'b1; t_val = CW'(SC - 1);
      end
      PH_SETUP: if (t_last) begin
        ph_nxt = PH_STROBE; t_load = 1'b1; t_val = CW'(TC - 1);
      end
      PH_STROBE: if (t_last) begin
        ph_nxt = PH_HOLD;   t_load = 1'b1; t_val = CW'(HC - 1);
      end
      PH_HOLD: if (t_last) begin
        ph_nxt = PH_TURN;   t_load = 1'b1; t_val = CW'(RC - 1);
      end
      PH_TURN: if (t_last) begin
        ph_nxt = PH_IDLE;
      end
      default: ph_nxt = PH_IDLE;
    endcase
  end

  assign req_ready = (ph == PH_IDLE);
  assign accept    = req_ready && req_valid;
  assign nxt_we    = accept ? req_we : op_we;
  assign nxt_busy  = ph_nxt inside {PH_SETUP, PH_STROBE, PH_HOLD};
  assign rsp_valid = (ph == PH_HOLD) && t_last;
  assign cap_rd    = (ph == PH_STROBE) && t_last && !op_we;

  // strobes come straight from flops so the memory never sees decode glitches
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      op_we    <= 1'b0;
      mem_ce_n <= 1'b1;
      mem_oe_n <= 1'b1;
      mem_we_n <= 1'b1;
      drive_en <= 1'b0;
    end else begin
      ph       <= ph_nxt;
      op_we    <= nxt_we;
      mem_ce_n <= !nxt_busy;
      mem_we_n <= !((ph_nxt == PH_STROBE) && nxt_we);
      mem_oe_n <= !((ph_nxt == PH_STROBE) && !nxt_we);
      drive_en <= nxt_busy && nxt_we;
    end
  end

  // run length of the current write-enable pulse, for the width check
  logic [RW-1:0] we_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         we_run <= '0;
    else if (mem_we_n)  we_run <= '0;
    else                we_run <= we_run + RW'(1);
  end

  assert_we_inside_ce_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);
  assert_we_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run == RW'(TC)));
  assert_oe_excludes_we_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> mem_we_n);
  assert_drive_needs_oe_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en |-> mem_oe_n);
  assert_drive_after_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_en) |-> ($past(mem_oe_n) && $past(mem_ce_n)));
  assert_rsp_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_ready_only_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && !drive_en));

endmodule

// File: rtl/asram_datapath.sv
`timescale 1ns/1ps
module asram_datapath #(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          cap_rd,
  input  logic          drive_en,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] rsp_rdata,
  inout  wire  [DW-1:0] mem_dq
);

  logic [DW-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr  <= '0;
      wdata_q   <= '0;
      rsp_rdata <= '0;
    end else begin
      if (accept) begin
        mem_addr <= req_addr;
        wdata_q  <= req_wdata;
      end
      if (cap_rd) rsp_rdata <= mem_dq;
    end
  end

  assign mem_dq = drive_en ? wdata_q : 'z;

  assert_no_accept_while_driving_R2: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en |-> !accept);
  assert_capture_not_driving_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_rd |-> !drive_en);
  assert_wdata_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en && $past(drive_en)) |-> $stable(mem_dq));

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl #(
  parameter int AW       = 15,
  parameter int DW       = 8,
  parameter int T_SETUP  = 1,
  parameter int T_STROBE = 2,
  parameter int T_HOLD   = 1,
  parameter int T_TURN   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  inout  wire  [DW-1:0] mem_dq
);

  logic accept, cap_rd, drive_en;

  asram_seq #(
    .T_SETUP  (T_SETUP),
    .T_STROBE (T_STROBE),
    .T_HOLD   (T_HOLD),
    .T_TURN   (T_TURN)
  ) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_we    (req_we),
    .req_ready (req_ready),
    .accept    (accept),
    .cap_rd    (cap_rd),
    .rsp_valid (rsp_valid),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .drive_en  (drive_en)
  );

  asram_datapath #(.AW(AW), .DW(DW)) i_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .cap_rd    (cap_rd),
    .drive_en  (drive_en),
    .mem_addr  (mem_addr),
    .rsp_rdata (rsp_rdata),
    .mem_dq    (mem_dq)
  );

  assert_addr_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
  assert_rsp_inside_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!mem_ce_n && mem_we_n && mem_oe_n));

endmodule

// File: tb/test_asram_ctrl.sv
`timescale 1ns/1ps
module test_asram_ctrl;

  localparam int AW = 8;
  localparam int DW = 8;
  localparam int S  = 1;
  localparam int T  = 2;
  localparam int H  = 1;
  localparam int R  = 1;
  localparam int WORDS = 1 << AW;
  localparam int MIN_PULSE_NS = 7;
  localparam int MIN_SETUP_NS = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n, mem_oe_n, mem_we_n;
  wire  [DW-1:0] mem_dq;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  asram_ctrl #(
    .AW(AW), .DW(DW), .T_SETUP(S), .T_STROBE(T), .T_HOLD(H), .T_TURN(R)
  ) i_asram_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq(mem_dq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural memory model ----------------
  logic [DW-1:0] store [WORDS];
  logic          model_sel;
  logic          model_en = 1'b0;
  logic          in_wr = 1'b0;
  time           t_wstart = 0;
  time           t_dchg = 0;

  assign model_sel = !mem_ce_n && !mem_oe_n && mem_we_n;
  assign mem_dq = model_en ? store[mem_addr] : 'z;

  always @(posedge model_sel) model_en = 1'b1;
  always @(negedge model_sel) model_en <= #6 1'b0;

  always @(mem_dq) t_dchg = $time;

  always @(negedge mem_we_n or negedge mem_ce_n)
    if (!mem_we_n && !mem_ce_n) begin
      in_wr    = 1'b1;
      t_wstart = $time;
    end

  always @(posedge mem_we_n or posedge mem_ce_n)
    if (in_wr) begin
      in_wr = 1'b0;
      chk(($time - t_wstart) >= MIN_PULSE_NS, "R4 write pulse width ns",
          int'($time - t_wstart), MIN_PULSE_NS);
      chk(($time - t_dchg) >= MIN_SETUP_NS, "R5 data setup before write end ns",
          int'($time - t_dchg), MIN_SETUP_NS);
      store[mem_addr] = mem_dq;
    end

  function automatic logic [DW-1:0] pat(input int a, input int seed);
    return DW'((a * 29 + seed * 71 + 3) % 256);
  endfunction

  logic [DW-1:0] expect_mem [WORDS];
  bit cur_we = 1'b0;

  // One access; on return the bench sits on the negedge where req_ready is back.
  // If chain is set, a follow-on request is presented while busy (R2).
  task automatic access(input bit we, input int a, input logic [DW-1:0] d,
                        input bit chain, input bit nwe, input int na,
                        input logic [DW-1:0] nd);
    int lastk;
    bit strb;
    lastk = S + T + H + R + 1;
    req_valid = 1'b1; req_we = we; req_addr = AW'(a); req_wdata = d;
    while (!req_ready) @(negedge clk);
    cur_we = we;
    @(negedge clk);
    if (chain) begin
      req_valid = 1'b1; req_we = nwe; req_addr = AW'(na); req_wdata = nd;
    end else begin
      req_valid = 1'b0; req_we = !we; req_addr = ~AW'(a); req_wdata = ~d;
    end
    for (int k = 1; k <= lastk; k++) begin
      strb = (k > S) && (k <= S + T);
      chk(mem_ce_n == (k > S + T + H), "R3 chip select window", mem_ce_n, k > S + T + H);
      if (k <= S + T + H)
        chk(mem_addr == AW'(a), "R3 address held", mem_addr, a);
      chk(mem_we_n == !(we && strb), "R4 write enable shape", mem_we_n, !(we && strb));
      chk(mem_oe_n == !(!we && strb), "R6 output enable shape", mem_oe_n, !(!we && strb));
      if (we && k <= S + T + H)
        chk(mem_dq == d, "R5 write data on bus", mem_dq, d);
      chk(!(we && model_en), "R9 bus contention", model_en, 0);
      chk(rsp_valid == (k == S + T + H), "R8 response pulse", rsp_valid, k == S + T + H);
      if (!we && k == S + T + H)
        chk(rsp_rdata == expect_mem[a], "R7 read data", rsp_rdata, expect_mem[a]);
      chk(req_ready == (k == lastk), "R9 ready after turnaround", req_ready, k == lastk);
      if (k < lastk) @(negedge clk);
    end
    if (we) begin
      expect_mem[a] = d;
      chk(store[a] == d, "R5 word stored", store[a], d);
    end
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) begin
      store[i] = '0;
      expect_mem[i] = '0;
    end
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes idle in reset",
        {mem_ce_n, mem_oe_n, mem_we_n}, 7);
    chk(!rsp_valid, "R1 no response in reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R1 ready after reset", req_ready, 1);
    chk(mem_ce_n, "R1 deselected after reset", mem_ce_n, 1);

    // sweep 1: write every word, then read every word back
    for (int a = 0; a < WORDS; a++) access(1'b1, a, pat(a, 1), 1'b0, 1'b0, 0, '0);
    for (int a = 0; a < WORDS; a++) access(1'b0, a, '0, 1'b0, 1'b0, 0, '0);

    // sweep 2: back-to-back requests held valid through the busy window (R2)
    for (int a = 0; a < WORDS; a += 2) begin
      access(1'b1, a, pat(a, 2), 1'b1, 1'b1, a + 1, pat(a + 1, 2));
      access(1'b1, a + 1, pat(a + 1, 2), 1'b1, 1'b0, a, '0);
      access(1'b0, a, '0, 1'b1, 1'b0, a + 1, '0);
      access(1'b0, a + 1, '0, 1'b0, 1'b0, 0, '0);
    end

    // alternating read/write in descending order
    for (int a = WORDS - 1; a >= 0; a -= 17) begin
      access(1'b0, a, '0, 1'b0, 1'b0, 0, '0);
      access(1'b1, a, pat(a, 3), 1'b0, 1'b0, 0, '0);
      access(1'b0, a, '0, 1'b0, 1'b0, 0, '0);
    end

    // idle: nothing happens without a request (R2)
    req_valid = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk(mem_ce_n && req_ready && !rsp_valid, "R2 idle without request",
          {mem_ce_n, req_ready, rsp_valid}, 6);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog R9 actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule